// File: doc/BRIEF.md
# External Interrupt Request Controller

The controller watches eight active-low external interrupt request lines and turns them into one interrupt output, a wake-up output and a vector code that software reads to find the source to service. Each line first passes through a two-flop synchronizer. Each line then has its own detection mode. In edge mode a falling transition latches a pending bit, which software clears by writing 1 to it. In level mode the pending bit follows the synchronized line, so it stays set for as long as the line is low.

A mask register gates every line except line 0, which can never be masked. A priority encoder gives lower-numbered lines precedence over higher-numbered ones. Line n produces the code 4*n, and the value 0x3C means that nothing unmasked is pending. Because the two low bits of every code are zero, software can use the code directly as a byte offset into a table of 4-byte entries. A line whose wake-up enable is set also raises the wake-up output whenever it has a pending request, whatever its mask bit says.

Software reaches the registers through a small synchronous write and combinational read bus. Reads may be a byte, a half-word or a word wide. The register words are big-endian, so byte 0 of a word is bits 31:24.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the configuration register, the mask register and all pending bits read 0 while the lines are held high. The vector register's code byte reads 0x3C, and `irq_o` and `wake_o` are low.
- R2: Edge mode. A falling transition on a line whose edge bit is 1 sets its pending bit. The bit stays set after the line returns high and clears only when 1 is written to that bit of the pending register (offset 0x0, line n at bit 31-n). Writing 0 to the bit has no effect.
- R3: Level mode. A line whose edge bit is 0 shows a pending bit equal to the inverse of the line. Writing 1 to that bit of the pending register does not clear it.
- R4: Line 0 is non-maskable. Mask bit 0 (offset 0x4, line n at bit 31-n, where 1 means masked) has no effect on `irq_o` or on the vector code.
- R5: The vector register (offset 0xC, bits 31:24, all other bits zero, writes ignored) holds 4*n for the lowest-numbered line n that is pending and not masked. It holds 0x3C when no such line exists. The two low bits of the code are always 0.
- R6: `irq_o` is high exactly when some pending line is unmasked or line 0 is pending.
- R7: `wake_o` is high exactly when some pending line has its wake-up bit set, whatever the mask says.
- R8: Reads return the addressed data right-justified in `bus_rdata`. Size 0 is a byte, with lane addr[1:0] and lane 0 = bits 31:24. Size 1 is a half-word, where addr[1]=0 selects bits 31:16. Size 2 or 3 is a whole word.
- R9: The configuration register at offset 0x8 holds line n's edge bit at bit 31-2n and its wake-up bit at bit 30-2n. Its lower 16 bits always read 0.
- R10: If a falling edge is detected in the same cycle that software writes 1 to that line's pending bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n_i | input | 8 | Asynchronous active-low request lines, line n on bit n |
| bus_wr | input | 1 | Word write strobe |
| bus_addr | input | 4 | Byte address within the register block |
| bus_size | input | 2 | Read size: 0 byte, 1 half-word, 2 or 3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, right-justified |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-up request out of low-power mode |

## Verification
A detected falling edge and a software write-1 clear can land on the same pending bit in the same clock cycle. With the line held high and its bit already pending, the bench drives the line low at a known time. It then asserts the clear write in exactly the cycle when the synchronized edge reaches the latch, three clock edges after the drive. It reads the pending register back and expects the bit to still be set, and it checks that a clear written in an idle cycle does remove the bit. The remaining stimulus is seeded random line patterns, masks and configurations, checked against a bench model of pending, vector, interrupt and wake-up.

// File: rtl/xirq_pkg.sv
// Package xirq_pkg
// Shared constants for the external interrupt controller: register
// offsets, read size codes and code widths. Assumes 32-bit registers.
package xirq_pkg;
    localparam int REG_W   = 32;
    localparam int CODE_W  = 8;
    localparam logic [3:0] OFF_PEND = 4'h0;
    localparam logic [3:0] OFF_MASK = 4'h4;
    localparam logic [3:0] OFF_CFG  = 4'h8;
    localparam logic [3:0] OFF_VEC  = 4'hC;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } rd_size_e;
endpackage

// File: rtl/xirq_sync.sv
// Module xirq_sync
// Per-bit multi-stage synchronizer for asynchronous request lines.
// Assumes lines idle high; every stage resets to 1 so that leaving
// reset creates no spurious falling edge.
module xirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw asynchronous lines
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // shift through the following stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
// Module xirq_detect
// Per-line request detection. In edge mode a 1->0 transition of the
// synchronized line sets a sticky latch that a write-1 clear removes
// (a new edge wins over a simultaneous clear). In level mode the
// pending bit is the inverse of the synchronized line.
// Assumes sync_i is already synchronous to clk.
module xirq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] edge_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] fall;

    // remember last synchronized value for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sync_i;
    end

    assign fall = prev_q & ~sync_i;

    genvar n;
    generate
        for (n = 0; n < W; n++) begin : g_line
            // sticky edge latch: mode off clears, edge sets, clear removes
            always_ff @(posedge clk) begin
                if (!rst_n)             latch_q[n] <= 1'b0;
                else if (!edge_en_i[n]) latch_q[n] <= 1'b0;
                else if (fall[n])       latch_q[n] <= 1'b1;
                else if (clr_i[n])      latch_q[n] <= 1'b0;
            end

            // R2: a detected edge in edge mode is latched next cycle
            p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_en_i[n] && fall[n]) |=> latch_q[n]);

            // R2: without a clear the latch holds
            p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_en_i[n] && latch_q[n] && !clr_i[n]) |=> latch_q[n]);

            // R10: edge and clear in the same cycle leaves the bit set
            p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_en_i[n] && fall[n] && clr_i[n]) |=> latch_q[n]);
        end
    endgenerate

    // select per-line pending source by mode
    always_comb begin
        for (int i = 0; i < W; i++)
            pend_o[i] = edge_en_i[i] ? latch_q[i] : ~sync_i[i];
    end
endmodule

// File: rtl/xirq_prio.sv
// Module xirq_prio
// Fixed-priority encoder: the lowest index among active lines wins and
// yields code index*STEP; with no active line the idle code is output.
// Assumes STEP is a multiple of 4 so the two low code bits stay zero.
module xirq_prio #(
    parameter int W      = 8,
    parameter int CODE_W = 8,
    parameter int STEP   = 4,
    parameter int IDLE   = 60
) (
    input  logic [W-1:0]      active_i,
    output logic [CODE_W-1:0] code_o
);
    // scan from the lowest priority up so the lowest index ends last
    always_comb begin
        code_o = CODE_W'(IDLE);
        for (int i = W - 1; i >= 0; i--)
            if (active_i[i]) code_o = CODE_W'(i * STEP);
    end

    // R5: code is always aligned to a 4-byte table entry
    always_comb begin
        p_code_align_r5: assert (code_o[1:0] == 2'b00);
    end
endmodule

// File: rtl/xirq_ctrl.sv
// Module xirq_ctrl
// Top of the external interrupt controller: synchronizes the request
// lines, detects edge or level requests, holds mask and configuration
// registers, encodes the vector and drives irq and wake outputs.
// Assumes word-wide writes and combinational reads, big-endian lanes.
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int LINES    = 8,
    parameter int SYNC_STG = 2,
    parameter int STEP     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_n_i,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_o,
    output logic             wake_o
);
    localparam int IDLE_CODE = 60;

    logic [LINES-1:0]  sync_l;
    logic [LINES-1:0]  pend;
    logic [LINES-1:0]  mask_q;
    logic [LINES-1:0]  edge_q;
    logic [LINES-1:0]  wake_q;
    logic [LINES-1:0]  clr;
    logic [LINES-1:0]  active;
    logic [CODE_W-1:0] code;
    logic [REG_W-1:0]  pend_w, mask_w, cfg_w, vec_w, sel_w;
    logic              wr_pend, wr_mask, wr_cfg;

    assign wr_pend = bus_wr && (bus_addr[3:2] == OFF_PEND[3:2]);
    assign wr_mask = bus_wr && (bus_addr[3:2] == OFF_MASK[3:2]);
    assign wr_cfg  = bus_wr && (bus_addr[3:2] == OFF_CFG[3:2]);

    xirq_sync #(.W(LINES), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_n_i), .sync_o(sync_l)
    );

    xirq_detect #(.W(LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_l),
        .edge_en_i(edge_q), .clr_i(clr), .pend_o(pend)
    );

    // decode write-1-clear bits, line n at bit 31-n
    always_comb begin
        for (int i = 0; i < LINES; i++)
            clr[i] = wr_pend && bus_wdata[REG_W-1-i];
    end

    // mask register write
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (wr_mask)
            for (int i = 0; i < LINES; i++) mask_q[i] <= bus_wdata[REG_W-1-i];
    end

    // configuration register write: edge and wake bits in pairs from the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            wake_q <= '0;
        end else if (wr_cfg) begin
            for (int i = 0; i < LINES; i++) begin
                edge_q[i] <= bus_wdata[REG_W-1-2*i];
                wake_q[i] <= bus_wdata[REG_W-2-2*i];
            end
        end
    end

    // line 0 bypasses its mask
    always_comb begin
        active    = pend & ~mask_q;
        active[0] = pend[0];
    end

    xirq_prio #(.W(LINES), .CODE_W(CODE_W), .STEP(STEP), .IDLE(IDLE_CODE)) u_prio (
        .active_i(active), .code_o(code)
    );

    assign irq_o  = |active;
    assign wake_o = |(pend & wake_q);

    // assemble register images for reading
    always_comb begin
        pend_w = '0;
        mask_w = '0;
        cfg_w  = '0;
        for (int i = 0; i < LINES; i++) begin
            pend_w[REG_W-1-i]   = pend[i];
            mask_w[REG_W-1-i]   = mask_q[i];
            cfg_w[REG_W-1-2*i]  = edge_q[i];
            cfg_w[REG_W-2-2*i]  = wake_q[i];
        end
        vec_w = {code, {(REG_W-CODE_W){1'b0}}};
    end

    // pick the addressed register
    always_comb begin
        unique case (bus_addr[3:2])
            OFF_PEND[3:2]: sel_w = pend_w;
            OFF_MASK[3:2]: sel_w = mask_w;
            OFF_CFG[3:2]:  sel_w = cfg_w;
            default:       sel_w = vec_w;
        endcase
    end

    // size and lane selection, right-justified, big-endian lanes
    always_comb begin
        bus_rdata = '0;
        case (bus_size)
            SZ_BYTE: bus_rdata[7:0]  = sel_w[(REG_W-1-8*bus_addr[1:0]) -: 8];
            SZ_HALF: bus_rdata[15:0] = bus_addr[1] ? sel_w[15:0] : sel_w[31:16];
            default: bus_rdata       = sel_w;
        endcase
    end

    // R4: a pending line 0 always raises the interrupt
    p_line0_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> irq_o);

    // R5: with no interrupt asserted the vector shows the idle code
    p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (code == CODE_W'(IDLE_CODE)));

    // R7: a wake-enabled pending line raises wake even when masked
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & wake_q & mask_q)) |-> wake_o);

    // R6: the interrupt drops exactly when the idle code is shown
    p_irq_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (code != CODE_W'(IDLE_CODE)));
endmodule

// File: tb/xirq_ctrl_bench.sv
// Bench for xirq_ctrl: directed corners plus seeded random patterns,
// compared against a behavioural model kept in the bench.
module xirq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_n = 8'hFF;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, wake_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_ed = '0, m_wm = '0, m_mask = '0, m_latch = '0;

    always #10 clk = ~clk;

    xirq_ctrl u_xirq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [7:0] exp_pend();
        return (m_ed & m_latch) | (~m_ed & ~irq_n);
    endfunction

    function automatic logic [7:0] exp_code();
        logic [7:0] act = exp_pend() & ~m_mask;
        act[0] = exp_pend()[0];
        for (int i = 0; i < 8; i++) if (act[i]) return 8'(4 * i);
        return 8'h3C;
    endfunction

    function automatic logic [31:0] to_word(input logic [7:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < 8; i++) w[31-i] = v[i];
        return w;
    endfunction

    function automatic logic [31:0] cfg_word(input logic [7:0] e, input logic [7:0] k);
        logic [31:0] w = '0;
        for (int i = 0; i < 8; i++) begin
            w[31-2*i] = e[i];
            w[30-2*i] = k[i];
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
        bus_addr = a;
        bus_size = sz;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_lines(input logic [7:0] v);
        @(negedge clk);
        m_latch = m_latch | (m_ed & irq_n & ~v);
        irq_n = v;
        wait_n(4);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        rd(4'h0, 2'd2, d); check({tag, " R2/R3 pend"}, d, to_word(exp_pend()));
        rd(4'hC, 2'd2, d); check({tag, " R5 vec"}, d, {exp_code(), 24'h0});
        check({tag, " R6 irq"}, 32'(irq_o), 32'(exp_code() != 8'h3C));
        check({tag, " R7 wake"}, 32'(wake_o), 32'(|(exp_pend() & m_wm)));
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  r;
        void'($urandom(32'd1234));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        rd(4'h8, 2'd2, d); check("R1 cfg", d, 32'h0);
        rd(4'h4, 2'd2, d); check("R1 mask", d, 32'h0);
        rd(4'h0, 2'd2, d); check("R1 pend", d, 32'h0);
        rd(4'hC, 2'd0, d); check("R1 vec byte", d, 32'h3C);
        check("R1 irq/wake", {30'h0, irq_o, wake_o}, 32'h0);

        // R9 layout and reserved bits, R8 read sizes
        m_ed = 8'b1010_0101; m_wm = 8'b0110_0011;
        wr(4'h8, cfg_word(m_ed, m_wm) | 32'h0000_FFFF);
        rd(4'h8, 2'd2, d); check("R9 cfg word", d, cfg_word(m_ed, m_wm));
        rd(4'h8, 2'd1, d); check("R8 half hi", d, {16'h0, cfg_word(m_ed, m_wm)[31:16]});
        rd(4'hA, 2'd1, d); check("R8 half lo", d, 32'h0);
        rd(4'h9, 2'd0, d); check("R8 byte1", d, {24'h0, cfg_word(m_ed, m_wm)[23:16]});

        // R2 edge on line 2
        m_ed = 8'h04; m_wm = 8'h00;
        wr(4'h8, cfg_word(m_ed, m_wm));
        set_lines(8'hFB);
        set_lines(8'hFF);
        check_all("R2 edge held");
        wr(4'h0, 32'h0);
        check_all("R2 write0");
        wr(4'h0, to_word(8'h04)); m_latch[2] = 1'b0;
        check_all("R2 clear");

        // R3 level on line 5 cannot be cleared
        set_lines(8'hDF);
        wr(4'h0, to_word(8'h20));
        check_all("R3 level");
        rd(4'hC, 2'd0, d); check("R5 code line5", d, 32'h14);
        set_lines(8'hFF);

        // R4 line0 with everything masked
        m_mask = 8'hFF; wr(4'h4, to_word(m_mask));
        set_lines(8'hDE);
        check_all("R4 nonmask");
        rd(4'hC, 2'd0, d); check("R4 code0", d, 32'h0);
        set_lines(8'hFF);
        m_mask = 8'h00; wr(4'h4, 32'h0);

        // R10 collision of edge and clear on line 3
        m_ed = 8'h08; m_wm = 8'h08; wr(4'h8, cfg_word(m_ed, m_wm));
        set_lines(8'hF7);
        set_lines(8'hFF);
        @(negedge clk);
        irq_n = 8'hF7;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = to_word(8'h08);
        @(negedge clk);
        bus_wr = 1'b0;
        m_latch[3] = 1'b1;
        wait_n(3);
        check_all("R10 collide");
        set_lines(8'hFF);
        wr(4'h0, to_word(8'h08)); m_latch[3] = 1'b0;
        check_all("R10 idle clear");

        // random mix
        for (int it = 0; it < 80; it++) begin
            r = 8'($urandom);
            case ($urandom % 4)
                0: set_lines(r);
                1: begin m_mask = r; wr(4'h4, to_word(r)); end
                2: begin
                       m_ed = r; m_wm = 8'($urandom);
                       m_latch = m_latch & m_ed;
                       wr(4'h8, cfg_word(m_ed, m_wm));
                   end
                default: begin
                       wr(4'h0, to_word(r));
                       m_latch = m_latch & ~r;
                   end
            endcase
            check_all("RND");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule